// File: doc/BRIEF.md
# UART FIFO Control Unit

This block sits between the register decoder of a UART and its serial engines. It holds a transmit queue and a receive queue of bytes. Each queue is 16 or 32 entries deep, chosen by a parameter. Software programs the unit through one write-only control byte. That byte turns the queues on, starts self-clearing soft resets of either direction, and picks the level at which the transmit interrupt fires.

On the receive side the unit raises a DMA request. The request rises when enough bytes have arrived, or when the receiver reports a one-cycle time-out pulse while data is waiting. It stays up until the receive queue drains. A mode input tells the unit which line mode is active, and an extended-mode input tells it whether the threshold field is live. In the high-speed infrared modes, and in the consumer infrared mode, the queues stay on whatever software wrote.

All four byte interfaces use valid/ready, and a byte moves when valid and ready are both high in the same cycle. A producer may hold valid high as long as it likes. If valid is high while ready is low, the byte is not queued and the push error flag of that queue is set. The producer keeps ownership of the byte and may offer it again. On the pop side the consumer raises ready only to take a byte it has seen as valid. A ready with no valid byte is treated as a pop from an empty queue and is flagged.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the control byte is all zero, so the queues are off, no soft reset is pending and no DMA request is raised. Both queues are empty, all four error flags are low, and `tx_irq` is high.
- R2: `fifo_en` is high when control bit 0 is 1, or when `mode_sel` is 2, 3 or 4 (the high-speed and consumer infrared modes). Otherwise `fifo_en` is low. The codes 0, 1 and 5–7 obey bit 0.
- R3: A queue accepts bytes up to DEPTH entries when `fifo_en` is high, and up to one entry when it is low. Its `push_ready` is low whenever it is at that capacity.
- R4: Writing control bit 1 as 1 drives `rx_soft_rst` high for exactly the following cycle. At the end of that cycle the receive queue is empty and both receive error flags are low. The transmit queue is not affected.
- R5: Writing control bit 2 as 1 drives `tx_soft_rst` high for exactly the following cycle. At the end of that cycle the transmit queue is empty and both transmit error flags are low. The receive queue is not affected.
- R6: Control bits 3, 6 and 7 have no effect on any output or on queue contents.
- R7: With `ext_mode` high, control bits 5:4 select the transmit threshold T, and `tx_irq` is high exactly while the transmit level is below T. For DEPTH 16, codes 0–3 give T = 1, 3, 9, 13. For DEPTH 32 they give T = 1, 7, 17, 25.
- R8: With `ext_mode` low, bits 5:4 are ignored and `tx_irq` is high exactly while the transmit queue is empty.
- R9: `rx_dma_req` rises in the cycle after the receive level reaches RX_DMA_LEVEL. It then stays high until the receive queue is empty.
- R10: A `rx_timeout` pulse raises `rx_dma_req` in the next cycle if the receive queue is not empty. If the queue is empty, the pulse is ignored.
- R11: A push while `push_ready` is low, or a pop while `pop_valid` is low, does not change the queue and sets the matching sticky error flag. The flag stays high until the soft reset of that direction.
- R12: Each queue returns bytes in the order they were accepted.
- R13: A receiver soft reset drops `rx_dma_req` at the end of the soft reset cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Write strobe for the control byte |
| ctl_wr_data | input | 8 | Control byte: [0] enable, [1] rx reset, [2] tx reset, [5:4] tx threshold code |
| mode_sel | input | 3 | Line mode: 0 UART, 1 slow IR, 2 medium IR, 3 fast IR, 4 consumer IR |
| ext_mode | input | 1 | Extended mode, makes the threshold field live |
| tx_push_valid | input | 1 | Transmit byte offered by the bus side |
| tx_push_data | input | WIDTH | Transmit byte |
| tx_push_ready | output | 1 | Transmit queue has room |
| tx_pop_valid | output | 1 | Transmit byte available to the serializer |
| tx_pop_data | output | WIDTH | Oldest transmit byte |
| tx_pop_ready | input | 1 | Serializer takes the byte |
| rx_push_valid | input | 1 | Receive byte offered by the deserializer |
| rx_push_data | input | WIDTH | Receive byte |
| rx_push_ready | output | 1 | Receive queue has room |
| rx_pop_valid | output | 1 | Receive byte available to the bus side |
| rx_pop_data | output | WIDTH | Oldest receive byte |
| rx_pop_ready | input | 1 | Bus side takes the byte |
| rx_timeout | input | 1 | One-cycle receive time-out pulse |
| fifo_en | output | 1 | Effective queue enable |
| rx_soft_rst | output | 1 | One-cycle receiver soft reset |
| tx_soft_rst | output | 1 | One-cycle transmitter soft reset |
| tx_irq | output | 1 | Transmit level below threshold |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_push_err | output | 1 | Sticky: push into full transmit queue |
| tx_pop_err | output | 1 | Sticky: pop from empty transmit queue |
| rx_push_err | output | 1 | Sticky: push into full receive queue |
| rx_pop_err | output | 1 | Sticky: pop from empty receive queue |

## Verification
The properties assume the following about the inputs:
- `rst_n` is held low for at least one edge before traffic starts.
- `mode_sel` and `ext_mode` change only between transfers.
- `rx_timeout` is a single-cycle pulse.
- Every transfer completes in the same cycle as its handshake.

The bench drives every input just after a falling edge and holds each strobe for exactly one rising edge, so the timing assumptions hold. It also sweeps every mode code, every threshold code in both extended settings, and every fill level from empty to full. Overflow and underflow are provoked only on purpose, right before the checks that expect the sticky flags.

// File: rtl/uart_fifo_ctl_pkg.sv
package uart_fifo_ctl_pkg;

  localparam logic [2:0] MODE_UART = 3'd0;
  localparam logic [2:0] MODE_SIR  = 3'd1;
  localparam logic [2:0] MODE_MIR  = 3'd2;
  localparam logic [2:0] MODE_FIR  = 3'd3;
  localparam logic [2:0] MODE_CIR  = 3'd4;

  // bit positions inside the control byte
  localparam int BIT_EN    = 0;
  localparam int BIT_RXCLR = 1;
  localparam int BIT_TXCLR = 2;
  localparam int BIT_THR   = 4;

  typedef struct packed {
    logic       fifo_en;
    logic       rx_clr;
    logic       tx_clr;
    logic [1:0] thr_code;
  } fifo_ctl_t;

  function automatic logic forces_fifo(input logic [2:0] m);
    return (m == MODE_MIR) || (m == MODE_FIR) || (m == MODE_CIR);
  endfunction

endpackage

// File: rtl/uart_fifo_ctl_reg.sv
module uart_fifo_ctl_reg
  import uart_fifo_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [2:0] mode_sel,
  input  logic       ext_mode,
  output fifo_ctl_t  ctl
);

  logic       en_q;
  logic       rx_clr_q;
  logic       tx_clr_q;
  logic [1:0] thr_q;
  logic       unused_rsvd;

  assign unused_rsvd = ^{wr_data[7:6], wr_data[3]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rx_clr_q <= 1'b0;
      tx_clr_q <= 1'b0;
      thr_q    <= 2'b00;
    end else begin
      rx_clr_q <= wr_en & wr_data[BIT_RXCLR];
      tx_clr_q <= wr_en & wr_data[BIT_TXCLR];
      if (wr_en) begin
        en_q  <= wr_data[BIT_EN];
        thr_q <= wr_data[BIT_THR+1:BIT_THR];
      end
    end
  end

  always_comb begin
    ctl.fifo_en  = en_q | forces_fifo(mode_sel);
    ctl.rx_clr   = rx_clr_q;
    ctl.tx_clr   = tx_clr_q;
    ctl.thr_code = ext_mode ? thr_q : 2'b00;
  end

endmodule

// File: rtl/uart_fifo_buf.sv
module uart_fifo_buf #(
  parameter  int DEPTH = 16,
  parameter  int WIDTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int LW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cap_one,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  output logic             push_ready,
  output logic             pop_valid,
  output logic [WIDTH-1:0] pop_data,
  input  logic             pop_ready,
  output logic [LW-1:0]    level,
  output logic [LW-1:0]    level_nxt,
  output logic             push_err,
  output logic             pop_err
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr;
  logic [AW-1:0]    rd_ptr;
  logic [LW-1:0]    cnt;
  logic [LW-1:0]    cap;
  logic             push_fire;
  logic             pop_fire;

  assign cap        = cap_one ? LW'(1) : LW'(DEPTH);
  assign push_ready = !clr && (cnt < cap);
  assign pop_valid  = !clr && (cnt != '0);
  assign push_fire  = push_valid && push_ready;
  assign pop_fire   = pop_ready && pop_valid;
  assign pop_data   = mem[rd_ptr];
  assign level      = cnt;

  always_comb begin
    if (clr) level_nxt = '0;
    else     level_nxt = cnt + LW'(push_fire) - LW'(pop_fire);
  end

  always_ff @(posedge clk) begin
    if (push_fire) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push_fire) wr_ptr <= wr_ptr + 1'b1;
      if (pop_fire)  rd_ptr <= rd_ptr + 1'b1;
      cnt <= level_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_err <= 1'b0;
      pop_err  <= 1'b0;
    end else if (clr) begin
      push_err <= 1'b0;
      pop_err  <= 1'b0;
    end else begin
      if (push_valid && !push_ready) push_err <= 1'b1;
      if (pop_ready && !pop_valid)   pop_err  <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_fifo_tx_irq.sv
module uart_fifo_tx_irq #(
  parameter  int DEPTH = 16,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic [LW-1:0] level,
  input  logic [1:0]    thr_code,
  output logic          irq
);

  logic [LW-1:0] thr;

  generate
    if (DEPTH == 32) begin : g_deep
      always_comb begin
        case (thr_code)
          2'd0:    thr = LW'(1);
          2'd1:    thr = LW'(7);
          2'd2:    thr = LW'(17);
          default: thr = LW'(25);
        endcase
      end
    end else begin : g_shallow
      always_comb begin
        case (thr_code)
          2'd0:    thr = LW'(1);
          2'd1:    thr = LW'(3);
          2'd2:    thr = LW'(9);
          default: thr = LW'(13);
        endcase
      end
    end
  endgenerate

  assign irq = level < thr;

endmodule

// File: rtl/uart_fifo_rx_dma.sv
module uart_fifo_rx_dma #(
  parameter  int DEPTH     = 16,
  parameter  int DMA_LEVEL = 4,
  localparam int LW        = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          timeout,
  input  logic [LW-1:0] level_nxt,
  output logic          req
);

  logic req_nxt;

  always_comb begin
    if (clr || level_nxt == '0)                        req_nxt = 1'b0;
    else if (level_nxt >= LW'(DMA_LEVEL) || timeout)   req_nxt = 1'b1;
    else                                               req_nxt = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req <= 1'b0;
    else        req <= req_nxt;
  end

endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_ctl_pkg::*;
#(
  parameter  int DEPTH        = 16,
  parameter  int WIDTH        = 8,
  parameter  int RX_DMA_LEVEL = 4,
  localparam int LW           = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr_en,
  input  logic [7:0]       ctl_wr_data,
  input  logic [2:0]       mode_sel,
  input  logic             ext_mode,
  input  logic             tx_push_valid,
  input  logic [WIDTH-1:0] tx_push_data,
  output logic             tx_push_ready,
  output logic             tx_pop_valid,
  output logic [WIDTH-1:0] tx_pop_data,
  input  logic             tx_pop_ready,
  input  logic             rx_push_valid,
  input  logic [WIDTH-1:0] rx_push_data,
  output logic             rx_push_ready,
  output logic             rx_pop_valid,
  output logic [WIDTH-1:0] rx_pop_data,
  input  logic             rx_pop_ready,
  input  logic             rx_timeout,
  output logic             fifo_en,
  output logic             rx_soft_rst,
  output logic             tx_soft_rst,
  output logic             tx_irq,
  output logic             rx_dma_req,
  output logic             tx_push_err,
  output logic             tx_pop_err,
  output logic             rx_push_err,
  output logic             rx_pop_err
);

  fifo_ctl_t     ctl;
  logic [LW-1:0] tx_level;
  logic [LW-1:0] tx_level_nxt;
  logic [LW-1:0] rx_level;
  logic [LW-1:0] rx_level_nxt;

  uart_fifo_ctl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (ctl_wr_en),
    .wr_data  (ctl_wr_data),
    .mode_sel (mode_sel),
    .ext_mode (ext_mode),
    .ctl      (ctl)
  );

  uart_fifo_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (ctl.tx_clr),
    .cap_one    (!ctl.fifo_en),
    .push_valid (tx_push_valid),
    .push_data  (tx_push_data),
    .push_ready (tx_push_ready),
    .pop_valid  (tx_pop_valid),
    .pop_data   (tx_pop_data),
    .pop_ready  (tx_pop_ready),
    .level      (tx_level),
    .level_nxt  (tx_level_nxt),
    .push_err   (tx_push_err),
    .pop_err    (tx_pop_err)
  );

  uart_fifo_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (ctl.rx_clr),
    .cap_one    (!ctl.fifo_en),
    .push_valid (rx_push_valid),
    .push_data  (rx_push_data),
    .push_ready (rx_push_ready),
    .pop_valid  (rx_pop_valid),
    .pop_data   (rx_pop_data),
    .pop_ready  (rx_pop_ready),
    .level      (rx_level),
    .level_nxt  (rx_level_nxt),
    .push_err   (rx_push_err),
    .pop_err    (rx_pop_err)
  );

  uart_fifo_tx_irq #(.DEPTH(DEPTH)) u_irq (
    .level    (tx_level),
    .thr_code (ctl.thr_code),
    .irq      (tx_irq)
  );

  uart_fifo_rx_dma #(.DEPTH(DEPTH), .DMA_LEVEL(RX_DMA_LEVEL)) u_dma (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctl.rx_clr),
    .timeout   (rx_timeout),
    .level_nxt (rx_level_nxt),
    .req       (rx_dma_req)
  );

  logic unused_tx_nxt;
  assign unused_tx_nxt = ^tx_level_nxt;

  assign fifo_en     = ctl.fifo_en;
  assign rx_soft_rst = ctl.rx_clr;
  assign tx_soft_rst = ctl.tx_clr;

endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter  int DEPTH = 16,
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr_en,
  input logic [2:0]    mode_sel,
  input logic          ext_mode,
  input logic          fifo_en,
  input logic          rx_soft_rst,
  input logic          tx_soft_rst,
  input logic          tx_pop_valid,
  input logic          rx_pop_valid,
  input logic          rx_push_valid,
  input logic          rx_push_ready,
  input logic          rx_timeout,
  input logic          tx_irq,
  input logic          rx_dma_req,
  input logic          tx_push_err,
  input logic          rx_pop_err,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level
);

  assert_mode_forces_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 3'd2 || mode_sel == 3'd3 || mode_sel == 3'd4) |-> fifo_en);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

  assert_rx_clr_self_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_soft_rst && !ctl_wr_en) |=> !rx_soft_rst);

  assert_rx_clr_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_soft_rst |=> !rx_pop_valid);

  assert_tx_clr_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_soft_rst |=> !tx_pop_valid);

  assert_legacy_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !tx_soft_rst) |-> (tx_irq == !tx_pop_valid));

  assert_dma_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dma_req) |-> ($past(rx_timeout) || $past(rx_push_valid && rx_push_ready)));

  assert_dma_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_pop_valid && !rx_soft_rst) |-> !rx_dma_req);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push_err && !tx_soft_rst) |=> tx_push_err);

  assert_pop_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop_err && !rx_soft_rst) |=> rx_pop_err);

endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctl_wr_en     (ctl_wr_en),
  .mode_sel      (mode_sel),
  .ext_mode      (ext_mode),
  .fifo_en       (fifo_en),
  .rx_soft_rst   (rx_soft_rst),
  .tx_soft_rst   (tx_soft_rst),
  .tx_pop_valid  (tx_pop_valid),
  .rx_pop_valid  (rx_pop_valid),
  .rx_push_valid (rx_push_valid),
  .rx_push_ready (rx_push_ready),
  .rx_timeout    (rx_timeout),
  .tx_irq        (tx_irq),
  .rx_dma_req    (rx_dma_req),
  .tx_push_err   (tx_push_err),
  .rx_pop_err    (rx_pop_err),
  .tx_level      (tx_level),
  .rx_level      (rx_level)
);

// File: tb/uart_fifo_ctl_bench.sv
`timescale 1ns/1ps
module uart_fifo_ctl_bench;

  localparam int D   = 16;
  localparam int W   = 8;
  localparam int DMA = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ctl_wr_en = 1'b0;
  logic [7:0]   ctl_wr_data = '0;
  logic [2:0]   mode_sel = '0;
  logic         ext_mode = 1'b0;
  logic         tx_push_valid = 1'b0;
  logic [W-1:0] tx_push_data = '0;
  logic         tx_push_ready;
  logic         tx_pop_valid;
  logic [W-1:0] tx_pop_data;
  logic         tx_pop_ready = 1'b0;
  logic         rx_push_valid = 1'b0;
  logic [W-1:0] rx_push_data = '0;
  logic         rx_push_ready;
  logic         rx_pop_valid;
  logic [W-1:0] rx_pop_data;
  logic         rx_pop_ready = 1'b0;
  logic         rx_timeout = 1'b0;
  logic         fifo_en, rx_soft_rst, tx_soft_rst, tx_irq, rx_dma_req;
  logic         tx_push_err, tx_pop_err, rx_push_err, rx_pop_err;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  uart_fifo_ctl #(.DEPTH(D), .WIDTH(W), .RX_DMA_LEVEL(DMA)) u_uart_fifo_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .mode_sel(mode_sel), .ext_mode(ext_mode),
    .tx_push_valid(tx_push_valid), .tx_push_data(tx_push_data), .tx_push_ready(tx_push_ready),
    .tx_pop_valid(tx_pop_valid), .tx_pop_data(tx_pop_data), .tx_pop_ready(tx_pop_ready),
    .rx_push_valid(rx_push_valid), .rx_push_data(rx_push_data), .rx_push_ready(rx_push_ready),
    .rx_pop_valid(rx_pop_valid), .rx_pop_data(rx_pop_data), .rx_pop_ready(rx_pop_ready),
    .rx_timeout(rx_timeout), .fifo_en(fifo_en), .rx_soft_rst(rx_soft_rst),
    .tx_soft_rst(tx_soft_rst), .tx_irq(tx_irq), .rx_dma_req(rx_dma_req),
    .tx_push_err(tx_push_err), .tx_pop_err(tx_pop_err),
    .rx_push_err(rx_push_err), .rx_pop_err(rx_pop_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    ctl_wr_en = 1'b1; ctl_wr_data = d;
    tick();
    ctl_wr_en = 1'b0; ctl_wr_data = '0;
  endtask

  task automatic tx_push(input logic [W-1:0] b);
    tx_push_valid = 1'b1; tx_push_data = b;
    tick();
    tx_push_valid = 1'b0;
  endtask

  task automatic tx_pop();
    tx_pop_ready = 1'b1;
    tick();
    tx_pop_ready = 1'b0;
  endtask

  task automatic rx_push(input logic [W-1:0] b);
    rx_push_valid = 1'b1; rx_push_data = b;
    tick();
    rx_push_valid = 1'b0;
  endtask

  task automatic rx_pop();
    rx_pop_ready = 1'b1;
    tick();
    rx_pop_ready = 1'b0;
  endtask

  task automatic pulse_timeout();
    rx_timeout = 1'b1;
    tick();
    rx_timeout = 1'b0;
  endtask

  function automatic int thr_of(input int code);
    case (code)
      0:       return 1;
      1:       return D / 4 - 1;
      2:       return D / 2 + 1;
      default: return 3 * D / 4 + 1;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1", "fifo_en", fifo_en, 0);
    chk("R1", "soft resets", {rx_soft_rst, tx_soft_rst}, 0);
    chk("R1", "dma", rx_dma_req, 0);
    chk("R1", "errors", {tx_push_err, tx_pop_err, rx_push_err, rx_pop_err}, 0);
    chk("R1", "queues empty", {tx_pop_valid, rx_pop_valid}, 0);
    chk("R1", "tx_irq", tx_irq, 1);

    // R2 enable vs mode sweep
    for (int m = 0; m < 8; m++) begin
      for (int e = 0; e < 2; e++) begin
        mode_sel = 3'(m);
        wr_ctl(8'(e));
        chk("R2", $sformatf("fifo_en mode %0d bit %0d", m, e), fifo_en,
            (e == 1 || m == 2 || m == 3 || m == 4) ? 1 : 0);
      end
    end
    mode_sel = 3'd0;

    // R3 capacity one when disabled
    wr_ctl(8'h00);
    chk("R3", "ready when empty, disabled", tx_push_ready, 1);
    tx_push(8'hA0);
    chk("R3", "ready at one, disabled", tx_push_ready, 0);
    chk("R12", "single byte", tx_pop_data, 8'hA0);
    tx_pop();
    chk("R3", "empty after pop", tx_pop_valid, 0);

    // R3 / R12 / R11 full depth when enabled
    wr_ctl(8'h01);
    for (int i = 0; i < D; i++) begin
      chk("R3", $sformatf("ready at %0d", i), tx_push_ready, 1);
      tx_push(8'(i * 7 + 3));
    end
    chk("R3", "ready when full", tx_push_ready, 0);
    tx_push(8'hEE);
    chk("R11", "tx push error", tx_push_err, 1);
    for (int i = 0; i < D; i++) begin
      chk("R12", $sformatf("order %0d", i), tx_pop_data, (i * 7 + 3) & 8'hFF);
      tx_pop();
    end
    chk("R11", "overflow byte dropped", tx_pop_valid, 0);
    tx_pop();
    chk("R11", "tx pop error", tx_pop_err, 1);
    repeat (3) tick();
    chk("R11", "errors sticky", {tx_push_err, tx_pop_err}, 3);

    // R5 tx soft reset, rx untouched
    tx_push(8'h11); tx_push(8'h22);
    rx_push(8'h33);
    wr_ctl(8'h05);
    chk("R5", "tx_soft_rst pulse", tx_soft_rst, 1);
    tick();
    chk("R5", "tx_soft_rst cleared", tx_soft_rst, 0);
    chk("R5", "tx empty", tx_pop_valid, 0);
    chk("R5", "tx errors cleared", {tx_push_err, tx_pop_err}, 0);
    chk("R5", "rx kept", rx_pop_data, 8'h33);

    // R4 rx soft reset, tx untouched
    tx_push(8'h44);
    rx_push(8'h55);
    rx_pop(); rx_pop(); rx_pop();
    chk("R11", "rx pop error", rx_pop_err, 1);
    rx_push(8'h66);
    wr_ctl(8'h03);
    chk("R4", "rx_soft_rst pulse", rx_soft_rst, 1);
    tick();
    chk("R4", "rx_soft_rst cleared", rx_soft_rst, 0);
    chk("R4", "rx empty", rx_pop_valid, 0);
    chk("R4", "rx error cleared", rx_pop_err, 0);
    chk("R4", "tx kept", tx_pop_data, 8'h44);

    // R6 reserved bits ignored
    tx_push(8'h77);
    wr_ctl(8'hC9);
    chk("R6", "no soft reset", {rx_soft_rst, tx_soft_rst}, 0);
    chk("R6", "enable taken", fifo_en, 1);
    tick();
    chk("R6", "tx head kept", tx_pop_data, 8'h44);
    tx_pop();
    chk("R6", "tx second kept", tx_pop_data, 8'h77);
    ext_mode = 1'b1;
    chk("R6", "threshold code 0", tx_irq, 0);
    tx_pop();
    chk("R6", "irq at empty", tx_irq, 1);

    // R7 / R8 threshold sweep
    for (int x = 0; x < 2; x++) begin
      for (int c = 0; c < 4; c++) begin
        ext_mode = x[0];
        wr_ctl(8'(c << 4) | 8'h05);
        tick();
        for (int n = 0; n <= D; n++) begin
          chk(x == 1 ? "R7" : "R8", $sformatf("irq code %0d level %0d", c, n), tx_irq,
              (n < thr_of(x == 1 ? c : 0)) ? 1 : 0);
          if (n < D) tx_push(8'(n));
        end
      end
    end
    ext_mode = 1'b0;

    // R9 dma threshold and hold
    wr_ctl(8'h03);
    tick();
    for (int n = 1; n <= D; n++) begin
      rx_push(8'(n));
      chk("R9", $sformatf("dma at level %0d", n), rx_dma_req, (n >= DMA) ? 1 : 0);
    end
    rx_push(8'hFF);
    chk("R11", "rx push error", rx_push_err, 1);
    for (int n = D - 1; n >= 0; n--) begin
      rx_pop();
      chk("R9", $sformatf("dma draining %0d", n), rx_dma_req, (n > 0) ? 1 : 0);
    end

    // R10 time-out
    pulse_timeout();
    chk("R10", "timeout on empty ignored", rx_dma_req, 0);
    rx_push(8'h01); rx_push(8'h02);
    chk("R10", "below level", rx_dma_req, 0);
    pulse_timeout();
    chk("R10", "timeout raises", rx_dma_req, 1);
    rx_pop();
    chk("R10", "holds while data", rx_dma_req, 1);
    rx_pop();
    chk("R10", "drops at empty", rx_dma_req, 0);

    // R13 soft reset drops dma
    rx_push(8'h03); rx_push(8'h04);
    pulse_timeout();
    chk("R13", "raised before reset", rx_dma_req, 1);
    wr_ctl(8'h03);
    tick();
    chk("R13", "dropped by soft reset", rx_dma_req, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule